// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Inserter and Checker

This block handles the CRC-4 multiframe that rides in the first bit of timeslot 0 on a 2048 kbit/s E1 line. It works one bit at a time. The frame number (0 to 15 within the multiframe) and the bit position (0 to 255 within the frame) of each bit come from an alignment stage upstream, which is not part of this block.

The transmit path is a bit stream with a valid/ready handshake, and the block adds no storage on it. It copies every payload bit unchanged and overwrites only bit position 0 of each frame. Into that position it writes one of three things:
- the CRC-4 check bits of the previous sub-multiframe,
- the multiframe alignment pattern,
- two far-end report bits.

A sub-multiframe is eight frames, and a multiframe is two sub-multiframes.

The receive path runs the same division over the incoming line. It compares the result with the check bits that arrive one sub-multiframe later and keeps one error flag for each half of the multiframe. The transmit path loops these flags back in its report bits.

Back-pressure rules for the transmit path:
- A bit is transferred on any clock edge where `s_valid` and `m_ready` are both high.
- `s_ready` follows `m_ready` combinationally.
- `m_valid` follows `s_valid` combinationally.
- While no transfer occurs, the CRC state does not advance.

The receive path has no ready signal, because a line cannot be stalled. Each cycle with `rx_valid` high consumes one bit.

Top module: `e1_crc4_mf`

## Requirements
- R1: Every transmit bit whose bit position is not 0 is copied unchanged from `s_data` to `m_data`. `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. A bit counts as transferred only when `s_valid` and `m_ready` are both high.
- R2: At bit position 0 of odd frames 1, 3, 5, 7, 9 and 11, the output carries the alignment pattern 0, 0, 1, 0, 1, 1, in that frame order.
- R3: At bit position 0 of even frames, the output carries the check bits C1 to C4, C1 first. Frames 0, 2, 4 and 6 carry them in the first half of the multiframe, and frames 8, 10, 12 and 14 carry them in the second half. The check bits are the remainder of dividing (the 2048 transmitted bits of the previous sub-multiframe, times x^4) by x^4+x+1, with the division processing bits in transmission order. The check-bit positions count as 0 in that computation. C1 is the coefficient of x^3.
- R4: Until the first sub-multiframe after reset has been fully transferred, every check-bit position is sent as 0.
- R5: Bit position 0 of frame 13 carries the inverse of `err_smf1`. Bit position 0 of frame 15 carries the inverse of `err_smf2`. In both, 1 means error free.
- R6: The receiver computes the remainder of each received sub-multiframe as in R3 and compares it with the four check bits received in the next sub-multiframe. On the last bit of frame 7, `err_smf2` is loaded with the result for the previous second half. On the last bit of frame 15, `err_smf1` is loaded with the result for the first half of the same multiframe. A value of 1 means mismatch.
- R7: The first sub-multiframe boundary after reset has no stored remainder to compare against, so it reports no error.
- R8: The error flags change only on the receive bit that ends a sub-multiframe. Between those bits they hold their value.
- R9: Reset clears both error flags and the CRC state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Transmit input bit valid |
| s_ready | output | 1 | Transmit input accepted (follows m_ready) |
| s_data | input | 1 | Transmit input bit |
| s_frame | input | 4 | Frame number of the transmit bit |
| s_bitpos | input | 8 | Bit position of the transmit bit within its frame |
| m_valid | output | 1 | Transmit output bit valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 1 | Transmit output bit |
| rx_valid | input | 1 | Received bit present |
| rx_bit | input | 1 | Received line bit |
| rx_frame | input | 4 | Frame number of the received bit |
| rx_bitpos | input | 8 | Bit position of the received bit within its frame |
| err_smf1 | output | 1 | Latched CRC mismatch for the first half of the multiframe |
| err_smf2 | output | 1 | Latched CRC mismatch for the second half of the multiframe |

## Verification
The hardest state to reach from the ports is a mismatch attributed to the correct half. The result lands one sub-multiframe after the damaged data, and it lands on a different flag depending on whether a data bit or a check bit was damaged. The bench loops the transmit output into the receiver and flips exactly one received bit in chosen multiframes: a payload bit, an alignment bit, or a check bit. A clean multiframe follows each damaged one, so the bench sees both the flag setting and the report bit going out inverted in the next multiframe. Stall cycles of both kinds are inserted inside every frame, to show that the CRC state does not advance while no bit is transferred.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;

  typedef enum logic [1:0] {
    SLOT_PAY,
    SLOT_CRC,
    SLOT_MFAS,
    SLOT_SPARE
  } slot_e;

  // Role of a bit given its frame number and bit position.
  function automatic slot_e slot_of(input int frame, input int bitpos, input int mf_frames);
    if (bitpos != 0)               return SLOT_PAY;
    if ((frame % 2) == 0)          return SLOT_CRC;
    if (frame < (mf_frames - 3))   return SLOT_MFAS;
    return SLOT_SPARE;
  endfunction

endpackage

// File: rtl/e1crc_lfsr.sv
module e1crc_lfsr #(
  parameter int              CRC_W = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  input  logic             close,
  output logic [CRC_W-1:0] rem,
  output logic             rem_vld
);
  logic [CRC_W-1:0] st, nxt;
  logic             fb;

  always_comb begin
    fb  = din ^ st[CRC_W-1];
    nxt = {st[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      rem     <= '0;
      rem_vld <= 1'b0;
    end else if (en) begin
      if (close) begin
        st      <= '0;
        rem     <= nxt;
        rem_vld <= 1'b1;
      end else begin
        st <= nxt;
      end
    end
  end

  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && close) |=> $stable(rem)); // R3

endmodule

// File: rtl/e1crc_tx.sv
module e1crc_tx
  import e1crc_pkg::*;
#(
  parameter int               FRAME_BITS = 256,
  parameter int               MF_FRAMES  = 16,
  parameter int               CRC_W      = 4,
  parameter logic [CRC_W-1:0] POLY       = 4'b0011,
  parameter int               MFAS_W     = 6,
  parameter logic [MFAS_W-1:0] MFAS_PAT  = 6'b001011,
  localparam int              FW         = $clog2(MF_FRAMES),
  localparam int              BW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          din,
  input  logic [FW-1:0] frame,
  input  logic [BW-1:0] bitpos,
  input  logic          rep1,
  input  logic          rep2,
  output logic          dout
);
  localparam int SMF_FRAMES = MF_FRAMES / 2;
  localparam int CIW        = $clog2(CRC_W);
  localparam int MIW        = $clog2(MFAS_W);

  slot_e            kind;
  logic [CIW-1:0]   c_sel;
  logic [MIW-1:0]   m_sel;
  logic             smf_end;
  logic [CRC_W-1:0] rem;
  logic             rem_vld;

  always_comb begin
    kind    = slot_of(int'(frame), int'(bitpos), MF_FRAMES);
    c_sel   = CIW'(CRC_W - 1 - ((int'(frame) / 2) % CRC_W));
    m_sel   = MIW'(MFAS_W - 1 - (int'(frame) / 2));
    smf_end = (bitpos == BW'(FRAME_BITS - 1)) &&
              ((int'(frame) % SMF_FRAMES) == SMF_FRAMES - 1);
    unique case (kind)
      SLOT_CRC:   dout = rem[c_sel];
      SLOT_MFAS:  dout = MFAS_PAT[m_sel];
      SLOT_SPARE: dout = (int'(frame) == MF_FRAMES - 3) ? ~rep1 : ~rep2;
      default:    dout = din;
    endcase
  end

  e1crc_lfsr #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (beat),
    .din     ((kind == SLOT_CRC) ? 1'b0 : dout),
    .close   (smf_end),
    .rem     (rem),
    .rem_vld (rem_vld)
  );

  AST_TX_ZERO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && kind == SLOT_CRC && !rem_vld) |-> !dout); // R4

endmodule

// File: rtl/e1crc_rx.sv
module e1crc_rx
  import e1crc_pkg::*;
#(
  parameter int               FRAME_BITS = 256,
  parameter int               MF_FRAMES  = 16,
  parameter int               CRC_W      = 4,
  parameter logic [CRC_W-1:0] POLY       = 4'b0011,
  localparam int              FW         = $clog2(MF_FRAMES),
  localparam int              BW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          din,
  input  logic [FW-1:0] frame,
  input  logic [BW-1:0] bitpos,
  output logic          err1,
  output logic          err2
);
  localparam int SMF_FRAMES = MF_FRAMES / 2;
  localparam int CIW        = $clog2(CRC_W);

  slot_e            kind;
  logic [CIW-1:0]   c_sel;
  logic             smf_end;
  logic             second_half;
  logic [CRC_W-1:0] cap;
  logic [CRC_W-1:0] rem;
  logic             rem_vld;
  logic             mism;

  always_comb begin
    kind        = slot_of(int'(frame), int'(bitpos), MF_FRAMES);
    c_sel       = CIW'(CRC_W - 1 - ((int'(frame) / 2) % CRC_W));
    smf_end     = (bitpos == BW'(FRAME_BITS - 1)) &&
                  ((int'(frame) % SMF_FRAMES) == SMF_FRAMES - 1);
    second_half = int'(frame) >= SMF_FRAMES;
    mism        = rem_vld && (cap != rem);
  end

  e1crc_lfsr #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (beat),
    .din     ((kind == SLOT_CRC) ? 1'b0 : din),
    .close   (smf_end),
    .rem     (rem),
    .rem_vld (rem_vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap  <= '0;
      err1 <= 1'b0;
      err2 <= 1'b0;
    end else if (beat) begin
      if (kind == SLOT_CRC) cap[c_sel] <= din;
      if (smf_end) begin
        if (second_half) err1 <= mism;
        else             err2 <= mism;
      end
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && smf_end) |=> $stable({err1, err2})); // R8

  AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && smf_end && !rem_vld) |=> (!err1 && !err2)); // R7

endmodule

// File: rtl/e1_crc4_mf.sv
module e1_crc4_mf #(
  parameter int   FRAME_BITS = 256,
  parameter int   MF_FRAMES  = 16,
  parameter logic [3:0] POLY = 4'b0011,
  parameter logic [5:0] MFAS_PAT = 6'b001011,
  localparam int  FW = $clog2(MF_FRAMES),
  localparam int  BW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_data,
  input  logic [FW-1:0] s_frame,
  input  logic [BW-1:0] s_bitpos,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_data,
  input  logic          rx_valid,
  input  logic          rx_bit,
  input  logic [FW-1:0] rx_frame,
  input  logic [BW-1:0] rx_bitpos,
  output logic          err_smf1,
  output logic          err_smf2
);
  localparam int CRC_W  = MF_FRAMES / 4;
  localparam int MFAS_W = MF_FRAMES / 2 - 2;

  logic tx_beat;

  assign s_ready = m_ready;
  assign m_valid = s_valid;
  assign tx_beat = s_valid && m_ready;

  e1crc_tx #(
    .FRAME_BITS (FRAME_BITS),
    .MF_FRAMES  (MF_FRAMES),
    .CRC_W      (CRC_W),
    .POLY       (POLY),
    .MFAS_W     (MFAS_W),
    .MFAS_PAT   (MFAS_PAT)
  ) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat   (tx_beat),
    .din    (s_data),
    .frame  (s_frame),
    .bitpos (s_bitpos),
    .rep1   (err_smf1),
    .rep2   (err_smf2),
    .dout   (m_data)
  );

  e1crc_rx #(
    .FRAME_BITS (FRAME_BITS),
    .MF_FRAMES  (MF_FRAMES),
    .CRC_W      (CRC_W),
    .POLY       (POLY)
  ) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat   (rx_valid),
    .din    (rx_bit),
    .frame  (rx_frame),
    .bitpos (rx_bitpos),
    .err1   (err_smf1),
    .err2   (err_smf2)
  );

endmodule

// File: tb/sim_e1_crc4_mf.sv
module sim_e1_crc4_mf;
  localparam int CLK_NS = 10;
  localparam int NV     = 9;
  // {inject, frame[3:0], bitpos[7:0], exp err_smf1, exp err_smf2} after the multiframe
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 4'd0,  8'd0,   1'b0, 1'b0},
    {1'b0, 4'd0,  8'd0,   1'b0, 1'b0},
    {1'b1, 4'd3,  8'd50,  1'b1, 1'b0},
    {1'b0, 4'd0,  8'd0,   1'b0, 1'b0},
    {1'b1, 4'd12, 8'd200, 1'b0, 1'b0},
    {1'b0, 4'd0,  8'd0,   1'b0, 1'b1},
    {1'b1, 4'd2,  8'd0,   1'b0, 1'b1},
    {1'b1, 4'd5,  8'd0,   1'b1, 1'b0},
    {1'b0, 4'd0,  8'd0,   1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_data = 1'b0, m_ready = 1'b0, inj = 1'b0;
  logic [3:0] s_frame = '0;
  logic [7:0] s_bitpos = '0;
  logic s_ready, m_valid, m_data, err_smf1, err_smf2;
  logic rx_valid, rx_bit;

  assign rx_valid = m_valid && m_ready;
  assign rx_bit   = m_data ^ inj;

  e1_crc4_mf u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_frame(s_frame), .s_bitpos(s_bitpos),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_frame(s_frame), .rx_bitpos(s_bitpos),
    .err_smf1(err_smf1), .err_smf2(err_smf2)
  );

  always #(CLK_NS/2) clk = ~clk;

  int nchk = 0, nbad = 0;
  logic [3:0] tcrc, thold, rcrc, rhold, rcap;
  logic tvld, rvld, e1, e2;
  logic [31:0] prng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] stp(input logic [3:0] s, input logic d);
    logic fb;
    fb = d ^ s[3];
    return {s[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction

  task automatic model_reset();
    tcrc = '0; thold = '0; rcrc = '0; rhold = '0; rcap = '0;
    tvld = 1'b0; rvld = 1'b0; e1 = 1'b0; e2 = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0; inj = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(err_smf1 == 1'b0 && err_smf2 == 1'b0, "R9 flags after reset",
        {err_smf1, err_smf2}, 0);
  endtask

  task automatic send_mf(input logic [14:0] v);
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 256; p++) begin
        logic d, ex, r, czero, mism;
        logic [3:0] tn, rn;
        string tag;
        prng = prng ^ (prng << 13); prng = prng ^ (prng >> 17); prng = prng ^ (prng << 5);
        d = prng[0];
        s_frame = 4'(f); s_bitpos = 8'(p); s_data = d;
        if (p == 100) begin
          // idle cycle, then a back-pressured cycle (R1)
          s_valid = 1'b0; m_ready = 1'b1; #1;
          chk(m_valid == 1'b0, "R1 m_valid follows s_valid", m_valid, 0);
          @(negedge clk);
          s_valid = 1'b1; m_ready = 1'b0; #1;
          chk(s_ready == 1'b0 && m_valid == 1'b1, "R1 back-pressure", {s_ready, m_valid}, 1);
          @(negedge clk);
        end
        s_valid = 1'b1; m_ready = 1'b1;
        inj = v[14] && (f == int'(v[13:10])) && (p == int'(v[9:2]));
        czero = (p == 0) && (f % 2 == 0);
        if (p != 0)             begin ex = d; tag = "R1 payload"; end
        else if (f % 2 == 0)    begin ex = thold[3 - ((f / 2) % 4)]; tag = tvld ? "R3 check bit" : "R4 zero check bit"; end
        else if (f < 13)        begin ex = 6'b001011 >> (5 - f / 2); tag = "R2 alignment"; end
        else if (f == 13)       begin ex = ~e1; tag = "R5 report 1"; end
        else                    begin ex = ~e2; tag = "R5 report 2"; end
        #1;
        if (p == 0 || p == 37) chk(m_data === ex, tag, m_data, ex);
        r  = ex ^ inj;
        tn = stp(tcrc, czero ? 1'b0 : ex);
        rn = stp(rcrc, czero ? 1'b0 : r);
        if (czero) rcap[3 - ((f / 2) % 4)] = r;
        if (p == 255 && (f % 8) == 7) begin
          thold = tn; tcrc = '0; tvld = 1'b1;
          mism = rvld && (rcap != rhold);
          tag = rvld ? "R6 flag update" : "R7 first boundary";
          rhold = rn; rcrc = '0; rvld = 1'b1;
          if (f >= 8) e1 = mism; else e2 = mism;
        end else begin
          tcrc = tn; rcrc = rn;
        end
        @(negedge clk);
        inj = 1'b0;
        if (p == 255 && (f % 8) == 7)
          chk({err_smf1, err_smf2} == {e1, e2}, tag, {err_smf1, err_smf2}, {e1, e2});
        if (f == 3 && p == 128)
          chk({err_smf1, err_smf2} == {e1, e2}, "R8 flags held", {err_smf1, err_smf2}, {e1, e2});
      end
    end
    chk({err_smf1, err_smf2} == v[1:0], "R6 table result", {err_smf1, err_smf2}, v[1:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) send_mf(VEC[i]);
    // Corner: flags set, then reset clears them and check bits restart at zero
    send_mf({1'b1, 4'd3, 8'd50, 1'b1, 1'b0});
    do_reset();
    send_mf({1'b0, 4'd0, 8'd0, 1'b0, 1'b0});
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule